// File: doc/BRIEF.md
# I2C Register Port

This block is an I2C target that lets a host read and write a bank of up to 128 byte-wide registers. SCL and SDA are brought into the system clock domain through a short synchronizer. The block detects Start and Stop conditions and compares the first byte after a Start against its 7-bit device address. The upper four bits of that address are fixed at `0010`. The lower three bits come from strap pins, which are captured once when reset is released. The block drives SDA only as an open-drain pull-down enable.

A write transfer carries a pointer byte followed by any number of data bytes. Bit 7 of the pointer byte turns on auto-increment and bits [6:0] select the register. A read transfer cannot load the pointer. It streams out the register at the current pointer, and then the following registers if auto-increment is on. To set the pointer before a read, the host sends a write that stops right after the pointer byte.

The register bank sits outside the block and is connected through a plain interface: address, write data, write strobe and read data. The interface has no valid/ready handshake and no back-pressure, because the bus is never stretched. The bank must accept every one-cycle write strobe, and it must present read data for `reg_addr` within the same cycle. The system clock must run at least ten times faster than SCL.

Top module: `i2c_regport`

## Requirements
- R1: A Start (SDA falling while SCL is high) moves the block into the address phase from any state, including partway through a transfer. A Stop (SDA rising while SCL is high) returns it to idle. Neither changes the pointer or the increment flag.
- R2: If the first byte's upper seven bits equal `{4'b0010, strap[2:0]}`, the block acknowledges by holding `sda_oe` at 1 for the ninth SCL pulse. Bit 0 of that byte selects the direction: 1 is read, 0 is write.
- R3: The strap value is captured in the first clock after reset is released. Later changes on `strap_i` do not change which address is acknowledged.
- R4: For a non-matching address, no byte is acknowledged and `sda_oe` stays 0. No register write occurs until the next Start.
- R5: In a write, the byte after the address loads the pointer. Bits [6:0] become the register index and bit 7 becomes the increment flag. The pointer byte is acknowledged.
- R6: After each register byte is written or read, the pointer advances by one if the increment flag is 1, wrapping from 127 to 0. If the flag is 0, the pointer stays fixed.
- R7: Each data byte after the pointer byte in a write is acknowledged. It produces a single one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer before any advance and `reg_wdata` equal to the byte.
- R8: A read sends the register at the current pointer, most significant bit first. If the host acknowledges, the next register follows. The read never loads the pointer.
- R9: After the host answers a read byte with NACK, the block releases SDA and drives nothing until the next Start or Stop.
- R10: `sda_oe` (1 = pull SDA low) changes only while SCL is low during normal transfers. In idle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Low device-address bits, captured after reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 7 | Register index (the pointer) |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
The register write strobe and the pointer auto-increment fall in the same system clock cycle. The strobe must still carry the pre-increment index while the pointer steps underneath it. This is provoked by multi-byte writes with the increment flag set, including bursts that cross index 127. It is judged by reading the bank back through the bus and comparing against a model that applies each byte at the old pointer and then advances. Random bursts of writes, reads and pointer-only preambles, with random increment flags, keep both functions colliding at many pointer values.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } port_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ptr.sv
module i2c_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW:0]   load_val,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          inc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      inc <= 1'b0;
    end else if (load) begin
      ptr <= load_val[AW-1:0];
      inc <= load_val[AW];
    end else if (step && inc) begin
      ptr <= ptr + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !inc && !load) |=> $stable(ptr)); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && inc && !load && ptr == '1) |=> (ptr == '0)); // R6
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [6-STRAP_W:0] DEV_HI = 4'b0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [7:0]         reg_wdata,
  output logic               reg_we,
  input  logic [7:0]         reg_rdata
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  port_state_e        state;
  logic [CNT_W-1:0]   cnt;
  logic               ack_slot, rw, matched, mack, oe_q;
  logic [7:0]         rx, tx;
  logic [STRAP_W-1:0] strap_q;
  logic               strap_done, we_q, step_q;
  logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic               active, byte_end, ptr_load, inc;
  logic [ADDR_W-1:0]  ptr;
  logic [6:0]         dev_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_i;
      strap_done <= 1'b1;
    end
  end

  assign dev_addr = {DEV_HI, strap_q};
  assign active   = state inside {ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA};
  assign byte_end = scl_fall && active && !ack_slot && (cnt == LAST_BIT);
  assign ptr_load = byte_end && (state == ST_PTR);

  i2c_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .load_val({rx[7], rx[ADDR_W-1:0]}), .step(step_q),
    .ptr(ptr), .inc(inc)
  );

  // Strobe and pointer step are registered together: the strobe sees the old pointer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      step_q <= 1'b0;
    end else begin
      we_q   <= byte_end && (state == ST_WDATA);
      step_q <= byte_end && (state inside {ST_WDATA, ST_RDATA});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ack_slot <= 1'b0;
      rw       <= 1'b0;
      matched  <= 1'b0;
      mack     <= 1'b0;
      oe_q     <= 1'b0;
      rx       <= '0;
      tx       <= '0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      ack_slot <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ack_slot <= 1'b0;
      oe_q     <= 1'b0;
    end else if (active && scl_rise) begin
      if (ack_slot) begin
        mack <= ~sda_s;
      end else if (cnt != LAST_BIT) begin
        rx  <= {rx[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end
    end else if (active && scl_fall) begin
      if (!ack_slot && cnt == LAST_BIT) begin
        ack_slot <= 1'b1;
        unique case (state)
          ST_ADDR: begin
            matched <= (rx[7:1] == dev_addr);
            rw      <= rx[0];
            oe_q    <= (rx[7:1] == dev_addr);
          end
          ST_PTR, ST_WDATA: oe_q <= 1'b1;
          default:          oe_q <= 1'b0;
        endcase
      end else if (ack_slot) begin
        ack_slot <= 1'b0;
        cnt      <= '0;
        oe_q     <= 1'b0;
        unique case (state)
          ST_ADDR: begin
            if (!matched) begin
              state <= ST_SKIP;
            end else if (rw) begin
              state <= ST_RDATA;
              tx    <= reg_rdata;
              oe_q  <= ~reg_rdata[7];
            end else begin
              state <= ST_PTR;
            end
          end
          ST_PTR:   state <= ST_WDATA;
          ST_RDATA: begin
            if (mack) begin
              tx   <= reg_rdata;
              oe_q <= ~reg_rdata[7];
            end else begin
              state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end else if (state == ST_RDATA && cnt != '0) begin
        tx   <= {tx[6:0], 1'b0};
        oe_q <= ~tx[6];
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr;
  assign reg_wdata = rx;
  assign reg_we    = we_q;

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR)); // R1
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_q)); // R3
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R7
  AST_WE_OLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (inc ? (reg_addr == $past(reg_addr) + 1'b1) : $stable(reg_addr))); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R10
  AST_OE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R10
endmodule

// File: tb/test_i2c_regport.sv
module test_i2c_regport;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_i = 3'b101;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] regs [128];
  logic [7:0] exp_regs [128];
  logic [6:0] exp_ptr = '0;
  logic       exp_inc = 1'b0;
  int n_chk = 0, n_bad = 0, we_count = 0, oe_bad = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  i2c_regport i_i2c_regport (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) if (reg_we) begin
    regs[reg_addr] <= reg_wdata;
    we_count <= we_count + 1;
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; w(Q); scl_m = 1'b1; w(Q); r = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~give_ack, r);
  endtask

  task automatic advance();
    if (exp_inc) exp_ptr = exp_ptr + 1'b1;
  endtask

  // Write transfer: address, pointer byte, then n data bytes
  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] pb, input int n, input logic hit);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({dev, 1'b0}, a); chk("R2 address ack", {7'd0, a}, {7'd0, hit});
    send_byte(pb, a);
    if (hit) begin
      chk("R5 pointer ack", {7'd0, a}, 8'd1);
      exp_ptr = pb[6:0]; exp_inc = pb[7];
    end else chk("R4 no ack pointer", {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      chk(hit ? "R7 data ack" : "R4 no ack data", {7'd0, a}, {7'd0, hit});
      if (hit) begin exp_regs[exp_ptr] = d; advance(); end
    end
    bus_stop(); w(2*Q);
  endtask

  task automatic rd_burst(input int n);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({4'b0010, 3'b101, 1'b1}, a); chk("R2 read address ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk("R8 read data", d, exp_regs[exp_ptr]);
      advance();
    end
    bus_stop(); w(2*Q);
  endtask

  task automatic compare_bank(input string req);
    int diff = 0;
    for (int i = 0; i < 128; i++) if (regs[i] !== exp_regs[i]) diff++;
    chk(req, 8'(diff), 8'd0);
  endtask

  initial begin
    logic a; logic [7:0] d; int wc;
    void'($urandom(32'd7321));
    for (int i = 0; i < 128; i++) begin regs[i] = 8'(i * 37 + 5); exp_regs[i] = 8'(i * 37 + 5); end
    w(5);
    rst_n = 1'b1;
    w(3);
    chk("R10 reset sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R7 reset reg_we", {7'd0, reg_we}, 8'd0);
    strap_i = 3'b010;   // R3: straps move after capture

    // R3: new strap value must not be acknowledged
    wc = we_count;
    wr_burst(7'h12, 8'h83, 2, 1'b0);
    chk("R4 no write on mismatch", 8'(we_count - wc), 8'd0);
    compare_bank("R4 bank untouched");

    // R5 R6 R7: increment burst crossing 127
    wr_burst(7'h15, 8'hFE, 4, 1'b1);
    compare_bank("R6 wrap write burst");
    chk("R6 pointer after wrap", {1'b0, exp_ptr}, 8'd2);

    // R8: preamble then sequential read across wrap
    wr_burst(7'h15, 8'hFD, 0, 1'b1);
    rd_burst(5);

    // R6: increment off, two writes to the same register
    wr_burst(7'h15, 8'h20, 2, 1'b1);
    compare_bank("R6 fixed pointer write");
    rd_burst(2);

    // R1: repeated start between pointer byte and read
    bus_start();
    send_byte({7'h15, 1'b0}, a); chk("R1 addr ack", {7'd0, a}, 8'd1);
    send_byte(8'h90, a); chk("R1 pointer ack", {7'd0, a}, 8'd1);
    exp_ptr = 7'h10; exp_inc = 1'b1;
    bus_start();
    send_byte({7'h15, 1'b1}, a); chk("R1 reread address ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, d); chk("R1 read after repeated start", d, exp_regs[exp_ptr]); advance();
    // R9: NACK then extra clocks must see a released line
    recv_byte(1'b0, d); chk("R8 second read byte", d, exp_regs[exp_ptr]); advance();
    recv_byte(1'b0, d); chk("R9 released after NACK", d, 8'hFF);
    bus_stop(); w(2*Q);
    // R1: stop kept pointer; read resumes from it
    rd_burst(1);

    // Random mix of bursts
    for (int t = 0; t < 40; t++) begin
      int op = int'($urandom % 3);
      int n  = 1 + int'($urandom % 4);
      if (op == 0) wr_burst(7'h15, 8'($urandom), n, 1'b1);
      else if (op == 1) rd_burst(n);
      else begin wr_burst(7'h15, 8'($urandom), 0, 1'b1); rd_burst(n); end
    end
    compare_bank("R7 bank after random traffic");
    chk("R10 sda_oe changed with SCL high", 8'(oe_bad), 8'd0);
    finish_run();
  end
endmodule